// File: doc/BRIEF.md
# Low-Speed Idle Wake-Up Timer

This block holds a down counter that runs freely on the low-speed clock and uses it to time a low-power idle state. Software picks one of several window lengths. Each time the low bits of the counter for that window wrap through zero, a window event occurs. The event sets a sticky pending flag, raises an interrupt request if that request is enabled, and ends idle if the processor is idling. Software cannot load, read, start or halt the counter, and its value after reset is not defined.

Software requests idle with a one-cycle pulse on `idle_req`. While `idle_active` is high, the main execution clock is gated. Idle ends on the next window event or on the external wake input, whichever comes first.

Because the counter phase is hidden, an idle entry made at an arbitrary time can last anywhere from a few cycles up to one full window. To get a stay of exactly one window, software must enter idle right after an observed event.

Changing the window select while the counter runs can set the pending flag without a real event. The block makes this case deterministic: every write that changes the select value sets the flag.

Top module: `idle_wake_timer`

## Requirements
- R1: After reset, the select field, the interrupt enable and the pending flag all read 0, and `irq` and `idle_active` are low.
- R2: The counter decrements on every clock whether or not the block is idle. With select code s below NUM_SEL, window events are exactly 2^(BASE_LOG+s) cycles apart.
- R3: Select codes of NUM_SEL and above act as the longest window, 2^(BASE_LOG+NUM_SEL-1) cycles.
- R4: A window event sets the pending flag on the next edge. A control write with bit 1 equal to 0 clears the flag, unless an event or a select change sets it in the same cycle. A control write with bit 1 equal to 1 leaves the flag unchanged.
- R5: `irq` is high exactly while both the pending flag and the enable (control bit 0) are set. When idle ends on a window event with the enable set, `irq` rises on the same edge that `idle_active` falls.
- R6: An `idle_req` pulse while not idle makes `idle_active` high from the next edge.
- R7: If idle is requested in the cycle right after a window event, `idle_active` stays high for exactly W-1 cycles, where W is the window length. It falls on the edge W cycles after that event.
- R8: An idle entry made r cycles after an event, with 0 <= r <= W-2, lasts W-1-r cycles. No entry lasts longer than W cycles.
- R9: `ext_wake` high while idle drops `idle_active` on the next edge and does not set the pending flag.
- R10: A write to the mode register with a value different from the current select sets the pending flag, even when the enable is 0. A write of the same value does not set it.
- R11: Register map: address 0 holds the select in bits [SEL_W-1:0]. Address 1 holds the enable in bit 0 and the pending flag in bit 1. Other bits of address 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst_n | input | 1 | Active-low reset of the control state (not the counter) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 mode, 1 control |
| reg_wdata | input | SEL_W | Register write data |
| reg_rdata | output | SEL_W | Register read data for `reg_addr` |
| idle_req | input | 1 | One-cycle idle request from software |
| ext_wake | input | 1 | External wake event |
| irq | output | 1 | Interrupt request |
| idle_active | output | 1 | High while idle; gates the execution clock |

## Verification
The embedded properties check the following on every cycle:
- the counter steps by one on each clock;
- an event sets the pending flag, and the flag stays set until cleared;
- a select change sets the flag;
- idle is entered, held and left on the right edges;
- `irq` rises when idle ends on an event with the enable set.

Some behaviour can only be shown by the bench's scenarios, because it depends on the hidden counter phase:
- the absolute window lengths per select code, including the clamped codes;
- the exact duration of a synchronised stay;
- the r-dependent duration of an unsynchronised entry.

// File: rtl/iwt_pkg.sv
`timescale 1ns/1ps
package iwt_pkg;

   typedef enum logic [0:0] {
      ADDR_MODE = 1'b0,
      ADDR_CTRL = 1'b1
   } iwt_addr_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_PEND_BIT = 1;

endpackage

// File: rtl/iwt_counter.sv
`timescale 1ns/1ps
module iwt_counter #(
   parameter int CNT_W     = 16,
   parameter bit CNT_RESET = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("iwt_counter: CNT_W must be at least 2");
      end

      if (CNT_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '1;
            else        cnt <= cnt - 1'b1;
         end
      end else begin : g_free
         // free running; value after power-up deliberately undefined
         always_ff @(posedge clk) begin
            cnt <= cnt - 1'b1;
         end
      end
   endgenerate

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R2

endmodule

// File: rtl/iwt_window_sel.sv
`timescale 1ns/1ps
module iwt_window_sel #(
   parameter int BASE_LOG = 12,
   parameter int NUM_SEL  = 5,
   parameter int SEL_W    = 3,
   localparam int CNT_W   = BASE_LOG + NUM_SEL - 1
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEL_W-1:0] sel,
   output logic             win_evt
);

   localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(NUM_SEL - 1);

   logic [NUM_SEL-1:0] hit;
   logic [SEL_W-1:0]   eff_sel;

   generate
      if (BASE_LOG < 1) begin : g_bad_base
         $error("iwt_window_sel: BASE_LOG must be at least 1");
      end
      if (NUM_SEL < 1 || (NUM_SEL - 1) >= (1 << SEL_W)) begin : g_bad_sel
         $error("iwt_window_sel: NUM_SEL does not fit SEL_W");
      end
      for (genvar s = 0; s < NUM_SEL; s++) begin : g_hit
         // low BASE_LOG+s bits wrap through zero once per 2^(BASE_LOG+s) cycles
         assign hit[s] = (cnt[BASE_LOG+s-1:0] == '0);
      end
   endgenerate

   assign eff_sel = (sel > MAX_CODE) ? MAX_CODE : sel;

   always_comb begin
      win_evt = 1'b0;
      for (int s = 0; s < NUM_SEL; s++) begin
         if (eff_sel == SEL_W'(s)) win_evt = hit[s];
      end
   end

endmodule

// File: rtl/iwt_regs.sv
`timescale 1ns/1ps
module iwt_regs
   import iwt_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_addr,
   input  logic [SEL_W-1:0] reg_wdata,
   output logic [SEL_W-1:0] reg_rdata,
   input  logic             win_evt,
   output logic [SEL_W-1:0] sel,
   output logic             irq_en,
   output logic             pend
);

   logic mode_wr, ctrl_wr, sel_chg, pend_clr;

   generate
      if (SEL_W < 2) begin : g_bad_w
         $error("iwt_regs: SEL_W must be at least 2");
      end
   endgenerate

   assign mode_wr  = reg_we && (iwt_addr_e'(reg_addr) == ADDR_MODE);
   assign ctrl_wr  = reg_we && (iwt_addr_e'(reg_addr) == ADDR_CTRL);
   assign sel_chg  = mode_wr && (reg_wdata != sel);
   assign pend_clr = ctrl_wr && !reg_wdata[CTRL_PEND_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel    <= '0;
         irq_en <= 1'b0;
         pend   <= 1'b0;
      end else begin
         if (mode_wr) sel    <= reg_wdata;
         if (ctrl_wr) irq_en <= reg_wdata[CTRL_EN_BIT];
         if (win_evt || sel_chg) pend <= 1'b1;
         else if (pend_clr)      pend <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (iwt_addr_e'(reg_addr) == ADDR_MODE) begin
         reg_rdata = sel;
      end else begin
         reg_rdata[CTRL_EN_BIT]   = irq_en;
         reg_rdata[CTRL_PEND_BIT] = pend;
      end
   end

   AST_PEND_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      win_evt |=> pend); // R4
   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !pend_clr) |=> pend); // R4
   AST_NO_SPONT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !win_evt && !sel_chg) |=> !pend); // R4
   AST_SEL_CHANGE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && (reg_wdata != sel)) |=> pend); // R10

endmodule

// File: rtl/iwt_idle_ctl.sv
`timescale 1ns/1ps
module iwt_idle_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req,
   input  logic ext_wake,
   input  logic win_evt,
   output logic idle_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idle_q <= 1'b0;
      else if (idle_q) idle_q <= !(win_evt || ext_wake);
      else             idle_q <= idle_req;
   end

   AST_IDLE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_q && idle_req) |=> idle_q); // R6
   AST_IDLE_EVT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q && win_evt) |=> !idle_q); // R7
   AST_IDLE_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q && ext_wake) |=> !idle_q); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q && !win_evt && !ext_wake) |=> idle_q); // R8

endmodule

// File: rtl/idle_wake_timer.sv
`timescale 1ns/1ps
module idle_wake_timer #(
   parameter int BASE_LOG  = 12,
   parameter int NUM_SEL   = 5,
   parameter int SEL_W     = 3,
   parameter bit CNT_RESET = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_addr,
   input  logic [SEL_W-1:0] reg_wdata,
   output logic [SEL_W-1:0] reg_rdata,
   input  logic             idle_req,
   input  logic             ext_wake,
   output logic             irq,
   output logic             idle_active
);

   localparam int CNT_W = BASE_LOG + NUM_SEL - 1;

   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] sel;
   logic             win_evt, irq_en, pend;

   iwt_counter #(.CNT_W(CNT_W), .CNT_RESET(CNT_RESET)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt)
   );

   iwt_window_sel #(.BASE_LOG(BASE_LOG), .NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_window_sel (
      .cnt     (cnt),
      .sel     (sel),
      .win_evt (win_evt)
   );

   iwt_regs #(.SEL_W(SEL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .win_evt   (win_evt),
      .sel       (sel),
      .irq_en    (irq_en),
      .pend      (pend)
   );

   iwt_idle_ctl u_idle_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_req (idle_req),
      .ext_wake (ext_wake),
      .win_evt  (win_evt),
      .idle_q   (idle_active)
   );

   assign irq = pend && irq_en;

   AST_IRQ_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_active && win_evt && irq_en) |=> (irq && !idle_active)); // R5

endmodule

// File: tb/idle_wake_timer_bench.sv
`timescale 1ns/1ps
module idle_wake_timer_bench;

   localparam int BASE_LOG = 6;
   localparam int NUM_SEL  = 5;
   localparam int SEL_W    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic reg_addr = 1'b0;
   logic [SEL_W-1:0] reg_wdata = '0;
   logic [SEL_W-1:0] reg_rdata;
   logic idle_req = 1'b0;
   logic ext_wake = 1'b0;
   logic irq, idle_active;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;
   logic cur_en = 1'b0;

   idle_wake_timer #(.BASE_LOG(BASE_LOG), .NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_idle_wake_timer (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_req(idle_req),
      .ext_wake(ext_wake), .irq(irq), .idle_active(idle_active));

   always #4 clk = ~clk;

   function automatic int win_len(int code);
      int s = (code >= NUM_SEL) ? NUM_SEL - 1 : code;
      return 1 << (BASE_LOG + s);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [SEL_W-1:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input logic a, input logic [SEL_W-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // clear pending, then stop at the first negedge following a window event
   task automatic sync_evt();
      logic [SEL_W-1:0] v;
      wr(1'b1, {1'b0, 1'b0, cur_en});
      for (int i = 0; i < 8 * win_len(NUM_SEL - 1); i++) begin
         rd(1'b1, v);
         if (v[1]) return;
         @(negedge clk);
      end
   endtask

   // start right after an event: clear pending, count cycles to next event
   task automatic measure_period(output int k);
      logic [SEL_W-1:0] v;
      sync_evt();
      reg_addr = 1'b1; reg_wdata = {1'b0, 1'b0, cur_en}; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      k = 1;
      for (int i = 0; i < 4 * win_len(NUM_SEL - 1); i++) begin
         rd(1'b1, v);
         if (v[1]) return;
         @(negedge clk);
         k++;
      end
   endtask

   // enter idle r cycles after an event, return idle duration in cycles
   task automatic idle_after(input int r, output int d);
      sync_evt();
      reg_addr = 1'b1; reg_wdata = {1'b0, 1'b0, cur_en}; reg_we = 1'b1;
      for (int i = 0; i < r; i++) begin
         @(negedge clk);
         reg_we = 1'b0;
      end
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0; reg_we = 1'b0;
      d = 0;
      while (idle_active && d < 4 * win_len(NUM_SEL - 1)) begin
         d++;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [SEL_W-1:0] v;
      int k, d, w, code, r;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1'b0, v); chk(v == 0, "R1 sel", v, 0);
      rd(1'b1, v); chk(v == 0, "R1 ctrl", v, 0);
      chk(irq == 0 && idle_active == 0, "R1 outputs", {irq, idle_active}, 0);

      // R11 register map readback
      wr(1'b0, 3'd2); rd(1'b0, v); chk(v == 2, "R11 mode readback", v, 2);
      wr(1'b1, 3'b101); rd(1'b1, v); chk(v[2] == 0 && v[0] == 1, "R11 ctrl bits", v, 1);
      wr(1'b1, 3'b000);
      cur_en = 1'b0;

      // R2 window spacing per select code
      for (int s = 0; s < 3; s++) begin
         wr(1'b0, SEL_W'(s));
         measure_period(k);
         chk(k == win_len(s), "R2 window length", k, win_len(s));
      end

      // R3 codes beyond range clamp to longest window
      wr(1'b0, 3'd7);
      measure_period(k);
      chk(k == win_len(7), "R3 clamped window", k, win_len(7));

      // R10 same-value write leaves pending clear, change sets it with enable low
      wr(1'b0, 3'd1);
      sync_evt();
      wr(1'b1, 3'b000);
      wr(1'b0, 3'd1);
      rd(1'b1, v); chk(v[1] == 0, "R10 same sel no pend", v[1], 0);
      wr(1'b0, 3'd0);
      rd(1'b1, v); chk(v[1] == 1, "R10 change sets pend", v[1], 1);
      chk(irq == 0, "R5 irq masked", irq, 0);

      // R4 writing 1 to pend bit keeps it, writing 0 clears
      wr(1'b1, 3'b010); rd(1'b1, v); chk(v[1] == 1, "R4 pend kept", v[1], 1);
      wr(1'b1, 3'b011); cur_en = 1'b1;
      chk(irq == 1, "R5 irq with enable", irq, 1);
      wr(1'b1, 3'b001); rd(1'b1, v); chk(v[1] == 0, "R4 pend cleared", v[1], 0);
      chk(irq == 0, "R5 irq follows pend", irq, 0);

      // R7 synchronised entry lasts exactly one window
      w = win_len(0);
      idle_after(0, d);
      chk(d == w - 1, "R7 synced idle", d, w - 1);
      chk(irq == 1, "R5 irq on exit", irq, 1);
      rd(1'b1, v); chk(v[1] == 1, "R4 pend on exit", v[1], 1);

      // R9 external wake
      sync_evt();
      reg_addr = 1'b1; reg_wdata = {1'b0, 1'b0, cur_en}; reg_we = 1'b1; idle_req = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; idle_req = 1'b0;
      chk(idle_active == 1, "R6 entry", idle_active, 1);
      repeat (3) @(negedge clk);
      ext_wake = 1'b1;
      @(negedge clk);
      ext_wake = 1'b0;
      chk(idle_active == 0, "R9 wake exit", idle_active, 0);
      rd(1'b1, v); chk(v[1] == 0, "R9 wake no pend", v[1], 0);

      // R8 random unsynchronised entries
      for (int it = 0; it < 14; it++) begin
         code = $urandom % 3;
         cur_en = 1'($urandom % 2);
         wr(1'b0, SEL_W'(code));
         w = win_len(code);
         r = $urandom % (w - 1);
         idle_after(r, d);
         chk(d == w - 1 - r, "R8 unsync duration", d, w - 1 - r);
         chk(d <= w, "R8 within window", d, w);
         chk(irq == cur_en, "R5 irq vs enable", irq, cur_en);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule